// File: doc/BRIEF.md
# Edge-Triggered Interrupt Line Controller

This block watches a parameterised set of asynchronous event lines and turns their edges into interrupt requests. Each line passes through a multi-flop synchroniser. Its synchronised level is then compared with the previous sample to detect edges. Two enable registers choose which polarities matter on each line. When an enabled edge is seen, a bit is latched in one of two separate pending registers, one for rising edges and one for falling edges.

Software reaches the block through a single-cycle register port. It can inject a rising event on any line through a self-clearing trigger register, and that injection bypasses the edge enables. It clears pending bits by writing ones to them. A per-line mask gates the pending state onto the interrupt outputs.

An edge that reaches the detector in the same cycle as a write to either enable register is discarded. This prevents a half-applied configuration from producing a spurious request.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0x0000_0000 and every interrupt output is low.
- R2: With bit i of the rising-enable register (offset 0x00) set, a 0-to-1 change on `ev_in[i]` sets bit i of the rising-pending register (offset 0x34) after the third rising clock edge that follows the change, and not earlier.
- R3: With bit i of the falling-enable register (offset 0x04) set, a 1-to-0 change on `ev_in[i]` sets bit i of the falling-pending register (offset 0x38). An edge whose polarity is not enabled sets no pending bit.
- R4: A line with both enables set records its rising edges only in the rising-pending register and its falling edges only in the falling-pending register.
- R5: If a detected edge coincides with a clock cycle in which the rising-enable or falling-enable register is written, no pending bit is set for that edge.
- R6: Writing 1 to bit i of the software-trigger register (offset 0x30) sets rising-pending bit i on the second clock edge after the write, whatever the enables hold. Writing 0 has no effect, and the register always reads 0.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit land in the same cycle, the bit stays set.
- R8: `irq_out[i]` is high exactly when rising-pending bit i or falling-pending bit i is set and bit i of the mask register (offset 0x08) is 1.
- R9: Register bits at or above NUM_LINES read 0 and ignore writes. Offsets outside the six mapped ones read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_in | input | NUM_LINES | Asynchronous event lines |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | NUM_LINES | Per-line interrupt request |

## Verification
The bench builds the block with NUM_LINES = 4, ADDR_W = 8 and two synchroniser stages. With these values the exact three-edge input latency can be counted directly. Writing all ones to a register then exposes the reserved upper 28 bits. Four lines are enough to give each scenario its own line, so a stray set on a neighbouring line shows up in the same read. The two-cycle delay of the software trigger allows a clear write to be placed on the very edge where the injected set lands, which exercises the set-over-clear rule.

// File: rtl/eic_pkg.sv
package eic_pkg;
   // Register byte offsets; bit i of each register belongs to line i.
   localparam int unsigned OFF_RISE_EN = 'h00;
   localparam int unsigned OFF_FALL_EN = 'h04;
   localparam int unsigned OFF_MASK    = 'h08;
   localparam int unsigned OFF_SWTRIG  = 'h30;
   localparam int unsigned OFF_RPEND   = 'h34;
   localparam int unsigned OFF_FPEND   = 'h38;
   localparam int unsigned DATA_W      = 32;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RISE_EN,
      SEL_FALL_EN,
      SEL_MASK,
      SEL_SWTRIG,
      SEL_RPEND,
      SEL_FPEND
   } reg_sel_e;
endpackage

// File: rtl/eic_sync_edge.sv
module eic_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eic_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level  = chain_q[STAGES-1];
   assign rise_o = level & ~prev_q;
   assign fall_o = ~level & prev_q;
endmodule

// File: rtl/eic_regs.sv
module eic_regs #(
   parameter int unsigned NUM_LINES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  eic_pkg::reg_sel_e    sel,
   input  logic                 we,
   input  logic [NUM_LINES-1:0] wdata,
   output logic [NUM_LINES-1:0] rise_en_o,
   output logic [NUM_LINES-1:0] fall_en_o,
   output logic [NUM_LINES-1:0] mask_o,
   output logic [NUM_LINES-1:0] sw_pulse_o,
   output logic                 cfg_wr_o
);
   import eic_pkg::*;

   logic [NUM_LINES-1:0] rise_en_q, fall_en_q, mask_q, sw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en_q <= '0;
         fall_en_q <= '0;
         mask_q    <= '0;
         sw_q      <= '0;
      end else begin
         // Trigger bits live for exactly one cycle after the write.
         sw_q <= (we && sel == SEL_SWTRIG) ? wdata : '0;
         if (we && sel == SEL_RISE_EN) rise_en_q <= wdata;
         if (we && sel == SEL_FALL_EN) fall_en_q <= wdata;
         if (we && sel == SEL_MASK)    mask_q    <= wdata;
      end
   end

   assign rise_en_o  = rise_en_q;
   assign fall_en_o  = fall_en_q;
   assign mask_o     = mask_q;
   assign sw_pulse_o = sw_q;
   assign cfg_wr_o   = we && (sel == SEL_RISE_EN || sel == SEL_FALL_EN);
endmodule

// File: rtl/eic_pending.sv
module eic_pending #(
   parameter int unsigned NUM_LINES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] set_i,
   input  logic [NUM_LINES-1:0] clr_i,
   output logic [NUM_LINES-1:0] pend_o
);
   logic [NUM_LINES-1:0] pend_q;

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pend_q[i] <= 1'b0;
            else if (set_i[i])  pend_q[i] <= 1'b1;
            else if (clr_i[i])  pend_q[i] <= 1'b0;
         end
      end
   endgenerate

   assign pend_o = pend_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
   parameter int unsigned NUM_LINES   = 4,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] ev_in,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic [NUM_LINES-1:0] irq_out
);
   import eic_pkg::*;

   localparam int unsigned PAD_W = DATA_W - NUM_LINES;

   generate
      if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_lines
         $error("edge_irq_ctrl: NUM_LINES must be within 1..32");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("edge_irq_ctrl: ADDR_W must reach offset 0x38");
      end
   endgenerate

   reg_sel_e             sel;
   logic [NUM_LINES-1:0] wdata_l;
   logic [NUM_LINES-1:0] rise_det, fall_det;
   logic [NUM_LINES-1:0] rise_en, fall_en, mask_q, sw_pulse;
   logic                 cfg_wr;
   logic [NUM_LINES-1:0] rise_set, fall_set, rise_clr, fall_clr;
   logic [NUM_LINES-1:0] rise_pend_q, fall_pend_q;
   logic [NUM_LINES-1:0] rd_lines;

   assign wdata_l = bus_wdata[NUM_LINES-1:0];

   generate
      if (NUM_LINES < 32) begin : g_unused
         logic unused_hi;
         assign unused_hi = ^bus_wdata[31:NUM_LINES];
      end
   endgenerate

   // Address decode
   always_comb begin
      sel = SEL_NONE;
      if      (bus_addr == ADDR_W'(OFF_RISE_EN)) sel = SEL_RISE_EN;
      else if (bus_addr == ADDR_W'(OFF_FALL_EN)) sel = SEL_FALL_EN;
      else if (bus_addr == ADDR_W'(OFF_MASK))    sel = SEL_MASK;
      else if (bus_addr == ADDR_W'(OFF_SWTRIG))  sel = SEL_SWTRIG;
      else if (bus_addr == ADDR_W'(OFF_RPEND))   sel = SEL_RPEND;
      else if (bus_addr == ADDR_W'(OFF_FPEND))   sel = SEL_FPEND;
   end

   // One synchroniser and edge detector per line
   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         eic_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(ev_in[i]),
            .rise_o  (rise_det[i]),
            .fall_o  (fall_det[i])
         );
      end
   endgenerate

   eic_regs #(.NUM_LINES(NUM_LINES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .we        (bus_we),
      .wdata     (wdata_l),
      .rise_en_o (rise_en),
      .fall_en_o (fall_en),
      .mask_o    (mask_q),
      .sw_pulse_o(sw_pulse),
      .cfg_wr_o  (cfg_wr)
   );

   // Hardware edges are dropped while the enables are being rewritten;
   // the software pulse is not subject to that guard.
   assign rise_set = (rise_det & rise_en & {NUM_LINES{~cfg_wr}}) | sw_pulse;
   assign fall_set =  fall_det & fall_en & {NUM_LINES{~cfg_wr}};
   assign rise_clr = (bus_we && sel == SEL_RPEND) ? wdata_l : '0;
   assign fall_clr = (bus_we && sel == SEL_FPEND) ? wdata_l : '0;

   eic_pending #(.NUM_LINES(NUM_LINES)) u_rise_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (rise_set),
      .clr_i (rise_clr),
      .pend_o(rise_pend_q)
   );

   eic_pending #(.NUM_LINES(NUM_LINES)) u_fall_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (fall_set),
      .clr_i (fall_clr),
      .pend_o(fall_pend_q)
   );

   // Read mux
   always_comb begin
      unique case (sel)
         SEL_RISE_EN: rd_lines = rise_en;
         SEL_FALL_EN: rd_lines = fall_en;
         SEL_MASK:    rd_lines = mask_q;
         SEL_RPEND:   rd_lines = rise_pend_q;
         SEL_FPEND:   rd_lines = fall_pend_q;
         default:     rd_lines = '0;
      endcase
   end

   generate
      if (NUM_LINES < 32) begin : g_pad
         assign bus_rdata = {{PAD_W{1'b0}}, rd_lines};
      end else begin : g_full
         assign bus_rdata = rd_lines;
      end
   endgenerate

   assign irq_out = (rise_pend_q | fall_pend_q) & mask_q;
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
   parameter int unsigned NUM_LINES = 4,
   parameter int unsigned ADDR_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_we,
   input logic [31:0]          bus_wdata,
   input logic [31:0]          bus_rdata,
   input logic [NUM_LINES-1:0] irq_out,
   input logic [NUM_LINES-1:0] rise_pend,
   input logic [NUM_LINES-1:0] fall_pend,
   input logic [NUM_LINES-1:0] mask
);
   import eic_pkg::*;

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rise_pend == '0 && fall_pend == '0 && irq_out == '0));

   // R6
   sw_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFF_SWTRIG)) |=> ##1
      ((rise_pend & $past(bus_wdata[NUM_LINES-1:0], 2)) == $past(bus_wdata[NUM_LINES-1:0], 2)));

   // R6
   sw_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_SWTRIG)) |-> bus_rdata == 32'h0);

   // R7
   rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == ADDR_W'(OFF_RPEND)) |=>
      ((rise_pend & $past(rise_pend)) == $past(rise_pend)));

   // R7
   fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == ADDR_W'(OFF_FPEND)) |=>
      ((fall_pend & $past(fall_pend)) == $past(fall_pend)));

   // R8
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~mask) == '0);

   // R9
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata >> NUM_LINES) == 32'h0);
endmodule

bind edge_irq_ctrl eic_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .irq_out  (irq_out),
   .rise_pend(rise_pend_q),
   .fall_pend(fall_pend_q),
   .mask     (mask_q)
);

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int AW = 8;

   localparam logic [AW-1:0] A_REN = 8'h00, A_FEN = 8'h04, A_MSK = 8'h08,
                             A_SWT = 8'h30, A_RPD = 8'h34, A_FPD = 8'h38;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  ev_in = '0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  irq_out;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] rd;

   edge_irq_ctrl #(.NUM_LINES(N), .ADDR_W(AW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      bus_we = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   task automatic clear_all();
      bus_write(A_RPD, 32'hF);
      bus_write(A_FPD, 32'hF);
      idle(1);
   endtask

   task automatic t_reset();
      bus_read(A_REN, rd); check("R1 rise enable", rd, 0);
      bus_read(A_FEN, rd); check("R1 fall enable", rd, 0);
      bus_read(A_MSK, rd); check("R1 mask", rd, 0);
      bus_read(A_RPD, rd); check("R1 rise pending", rd, 0);
      bus_read(A_FPD, rd); check("R1 fall pending", rd, 0);
      check("R1 irq", 32'(irq_out), 0);
   endtask

   task automatic t_rise();
      bus_write(A_REN, 32'h1);
      idle(1);
      @(negedge clk); ev_in[0] = 1'b1;
      repeat (2) @(posedge clk);
      bus_read(A_RPD, rd); check("R2 not before third edge", rd, 0);
      @(posedge clk);
      bus_read(A_RPD, rd); check("R2 set after third edge", rd, 32'h1);
      bus_read(A_FPD, rd); check("R2 no fall pending", rd, 0);
      clear_all();
   endtask

   task automatic t_fall();
      bus_write(A_REN, 32'h1);
      bus_write(A_FEN, 32'h4);
      idle(1);
      @(negedge clk); ev_in[2] = 1'b1;
      idle(4);
      bus_read(A_RPD, rd); check("R3 disabled rise ignored", rd, 0);
      @(negedge clk); ev_in[2] = 1'b0;
      idle(4);
      bus_read(A_FPD, rd); check("R3 fall pending", rd, 32'h4);
      clear_all();
   endtask

   task automatic t_both();
      bus_write(A_REN, 32'h9);
      bus_write(A_FEN, 32'hC);
      idle(1);
      @(negedge clk); ev_in[3] = 1'b1;
      idle(4);
      bus_read(A_RPD, rd); check("R4 rise recorded", rd, 32'h8);
      bus_read(A_FPD, rd); check("R4 fall empty", rd, 0);
      @(negedge clk); ev_in[3] = 1'b0;
      idle(4);
      bus_read(A_FPD, rd); check("R4 fall recorded", rd, 32'h8);
      clear_all();
      bus_read(A_RPD, rd); check("R7 w1c clears", rd, 0);
   endtask

   task automatic t_cfg_drop();
      bus_write(A_REN, 32'h2);
      idle(1);
      @(negedge clk); ev_in[1] = 1'b1;
      repeat (2) @(posedge clk);
      // Detector is active in this cycle; overlap it with an enable write.
      bus_write(A_FEN, 32'h0);
      idle(3);
      bus_read(A_RPD, rd); check("R5 edge dropped on cfg write", rd, 0);
      @(negedge clk); ev_in[1] = 1'b0;
      idle(4);
   endtask

   task automatic t_swtrig();
      bus_write(A_REN, 32'h0);
      bus_write(A_SWT, 32'h0);
      idle(2);
      bus_read(A_RPD, rd); check("R6 write of 0 no effect", rd, 0);
      bus_write(A_SWT, 32'h4);
      bus_read(A_RPD, rd); check("R6 not yet after one edge", rd, 0);
      bus_read(A_RPD, rd); check("R6 set after second edge", rd, 32'h4);
      bus_read(A_SWT, rd); check("R6 reads zero", rd, 0);
      clear_all();
   endtask

   task automatic t_collide();
      bus_write(A_SWT, 32'h2);
      bus_write(A_RPD, 32'h2);
      idle(1);
      bus_read(A_RPD, rd); check("R7 set wins over clear", rd, 32'h2);
      bus_write(A_RPD, 32'h0);
      idle(1);
      bus_read(A_RPD, rd); check("R7 write 0 keeps bit", rd, 32'h2);
   endtask

   task automatic t_mask();
      bus_write(A_MSK, 32'h0);
      idle(1);
      @(negedge clk); check("R8 masked irq low", 32'(irq_out), 0);
      bus_write(A_MSK, 32'h2);
      idle(1);
      @(negedge clk); check("R8 unmasked irq high", 32'(irq_out), 32'h2);
      bus_write(A_RPD, 32'h2);
      idle(1);
      @(negedge clk); check("R8 irq drops on clear", 32'(irq_out), 0);
   endtask

   task automatic t_reserved();
      bus_write(A_MSK, 32'hFFFF_FFFF);
      idle(1);
      bus_read(A_MSK, rd); check("R9 reserved bits zero", rd, 32'hF);
      bus_write(8'h10, 32'hFFFF_FFFF);
      idle(1);
      bus_read(8'h10, rd); check("R9 unmapped reads zero", rd, 0);
      bus_read(A_REN, rd); check("R9 unmapped write no effect", rd, 0);
      bus_read(A_FEN, rd); check("R9 fall enable untouched", rd, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_rise();
      t_fall();
      t_both();
      t_cfg_drop();
      t_swtrig();
      t_collide();
      t_mask();
      t_reserved();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule